// File: doc/BRIEF.md
# Configuration Register Slave on a Two-Wire Serial Bus

This block is a slave on a standard I2C bus (up to 400 kHz) that gives a host access to a small map of configuration registers for a multi-channel supply monitor. SCL and SDA are sampled with the local system clock. Each line passes through a two-stage synchronizer and a two-sample agreement filter. START and STOP are found from SDA edges while SCL is high. The slave pulls SDA low through an open-drain enable and never stretches the clock.

Every transaction moves one register address byte and one data byte. A write has three bytes, each acknowledged. A read first sends the register address and then uses a repeated START with the read bit to return one byte. The bus address is 0x34 plus a two-bit strap value. Some registers feed the core at once. The sequence-control registers are staged and only copied to the core when the sequencer pulses a commit input at a cycle boundary. Two lock bits stay set until reset. One refuses writes and the other makes the slave deaf to the bus.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x34 + addr_strap. Any other address gets no acknowledge, and SDA stays released for the rest of that transaction.
- R2: A write is START, address with R/W=0, register byte, data byte, STOP. The slave acknowledges all three bytes by pulling SDA low during the ninth clock. Bits travel MSB first, and the slave changes SDA only while SCL is low.
- R3: A read is a register-address phase, then a repeated START with R/W=1, then one data byte sent MSB first. Only one data byte is accepted per write transaction. A second data byte is not acknowledged and changes nothing.
- R4: Register 0x00 reads 0x4F and register 0x01 reads 0x2D. Writes to them change nothing.
- R5: After reset, register 0x04 reads 0x0F, register 0x08 reads 0x07, and all other registers read 0. The core outputs show the same values: chan_en=0x0F, out_cm=7, all others 0.
- R6: Registers 0x04 (enables; bit 7 ground reference, bits 5:4 auxiliary monitors, bits 3:0 main channels), 0x05 (start skip in bits 7:4, end skip in bits 3:0) and 0x06 (alternating polarity in bit 7) are staged. A read returns the staged value. chan_en, skip_start, skip_end and alt_pol take the staged value only on the clock after seq_commit is high.
- R7: Register 0x07 bits 1:0 (out_offset), 0x08 bits 3:0 (out_cm) and 0x0F bit 7 (timeout_off) reach their outputs directly after the write. So do the gain codes in bits 5:1 of 0x10..0x13 (bus gain, channel n at bus_gain_flat[5n+4:5n]) and 0x20..0x23 (shunt gain, same packing).
- R8: Unused bits of mapped registers read 0: the masks are 0xBF for 0x04, 0x80 for 0x06 and 0x0F, 0x03 for 0x07 and 0x24, 0x0F for 0x08, and 0x3E for the gains. Unmapped addresses read 0x00 and ignore writes.
- R9: Writing 1 to bit 1 of 0x24 locks writes. Reads still work, but the data byte of any later write is not acknowledged and changes nothing. The bit clears only by reset.
- R10: Writing 1 to bit 0 of 0x24 makes the slave ignore all bus activity, and it never acknowledges again. The bit clears only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addr_strap | input | 2 | Added to 0x34 to form the bus address |
| seq_commit | input | 1 | Pulse at a sequence boundary; copies staged registers to the core |
| chan_en | output | 8 | Active channel enables (from 0x04) |
| skip_start | output | 4 | Active start-skip count |
| skip_end | output | 4 | Active end-skip count |
| alt_pol | output | 1 | Active alternating-polarity enable |
| out_offset | output | 2 | Output offset select |
| out_cm | output | 4 | Output common-mode select |
| timeout_off | output | 1 | Sequence timeout disable |
| bus_gain_flat | output | 20 | Four 5-bit bus-voltage gain codes |
| shunt_gain_flat | output | 20 | Four 5-bit shunt gain codes |

## Verification
The checker watches on every cycle that SDA only moves while the filtered SCL is low, and that the two lock bits never clear. It also checks that no register write happens under the write lock, that a fully locked slave stays off SDA once released, and that the core enables hold except on the cycle after a commit, when they take the staged value. Address matching, the acknowledge pattern of each byte, the read path through a repeated START, and the masking and defaults of every register can only be shown by whole bus transactions. The same holds for the refused second data byte and for read-back through the write lock, so the bench drives them as scenarios.

// File: rtl/cfg_i2c_pkg.sv
// Package: register offsets, identity values and frame-engine states.
// Assumes an 8-bit register address space with one data byte per access.
package cfg_i2c_pkg;
    localparam logic [7:0] REG_ID0   = 8'h00;
    localparam logic [7:0] REG_ID1   = 8'h01;
    localparam logic [7:0] REG_ENA   = 8'h04;
    localparam logic [7:0] REG_SKIP  = 8'h05;
    localparam logic [7:0] REG_POL   = 8'h06;
    localparam logic [7:0] REG_OFS   = 8'h07;
    localparam logic [7:0] REG_CM    = 8'h08;
    localparam logic [7:0] REG_TMO   = 8'h0F;
    localparam logic [7:0] BUS_BASE  = 8'h10;
    localparam logic [7:0] SHN_BASE  = 8'h20;
    localparam logic [7:0] REG_LOCK  = 8'h24;

    localparam logic [7:0] ID0_VAL   = 8'h4F;
    localparam logic [7:0] ID1_VAL   = 8'h2D;
    localparam logic [7:0] ENA_RST   = 8'h0F;
    localparam logic [7:0] ENA_MASK  = 8'hBF;
    localparam logic [3:0] CM_RST    = 4'h7;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_ADDR,
        FS_REG,
        FS_WDATA,
        FS_ACK,
        FS_RDATA,
        FS_MACK,
        FS_DONE
    } frame_state_t;
endpackage

// File: rtl/cfg_pin_filter.sv
// Synchronizes one bus line into the clock domain and passes a new level
// only after two consecutive synchronized samples agree.
// Assumes the bus idles high, so every stage resets to 1.
module cfg_pin_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);
    logic [1:0] sync_q;
    logic       hist_q;

    // Two-flop synchronizer, one-sample history, agreement filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            hist_q  <= 1'b1;
            level_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], pin_i};
            hist_q <= sync_q[1];
            if (sync_q[1] == hist_q)
                level_o <= hist_q;
        end
    end
endmodule

// File: rtl/cfg_frame_engine.sv
// Bit-level frame engine: finds START/STOP and SCL edges on the filtered
// lines, shifts bytes in and out, and drives acknowledge bits. One
// register byte and one data byte per transaction; later bytes are refused.
// Assumes SCL is never held low by this slave.
module cfg_frame_engine
    import cfg_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [6:0] dev_addr,
    input  logic       lock_all,
    input  logic       lock_wr,
    input  logic [7:0] rd_data,
    output logic [7:0] reg_ptr,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic       sda_oe
);
    frame_state_t state_q, next_q;
    logic         scl_q, sda_q;
    logic [3:0]   cnt_q;
    logic [7:0]   rx_q, tx_q;
    logic         start_ev, stop_ev, rise_ev, fall_ev;

    assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
    assign rise_ev  = ~scl_q & scl_f;
    assign fall_ev  = scl_q & ~scl_f;

    // Open-drain drive: acknowledge slots and zero bits of read data.
    assign sda_oe = (state_q == FS_ACK) | ((state_q == FS_RDATA) & ~tx_q[7]);

    // Frame sequencing, byte shifting and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            next_q  <= FS_IDLE;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            cnt_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            reg_ptr <= '0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            wr_en <= 1'b0;
            if (stop_ev) begin
                state_q <= FS_IDLE;
            end else if (start_ev) begin
                state_q <= lock_all ? FS_IDLE : FS_ADDR;
                cnt_q   <= '0;
            end else begin
                case (state_q)
                    FS_ADDR, FS_REG, FS_WDATA: begin
                        if (rise_ev && cnt_q < 4'd8) begin
                            rx_q  <= {rx_q[6:0], sda_f};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (fall_ev && cnt_q == 4'd8) begin
                            cnt_q <= '0;
                            if (state_q == FS_ADDR) begin
                                if (rx_q[7:1] == dev_addr) begin
                                    state_q <= FS_ACK;
                                    if (rx_q[0]) begin
                                        next_q <= FS_RDATA;
                                        tx_q   <= rd_data;
                                    end else begin
                                        next_q <= FS_REG;
                                    end
                                end else begin
                                    state_q <= FS_IDLE;
                                end
                            end else if (state_q == FS_REG) begin
                                reg_ptr <= rx_q;
                                state_q <= FS_ACK;
                                next_q  <= FS_WDATA;
                            end else if (!lock_wr) begin
                                wr_en   <= 1'b1;
                                wr_data <= rx_q;
                                state_q <= FS_ACK;
                                next_q  <= FS_DONE;
                            end else begin
                                state_q <= FS_DONE;
                            end
                        end
                    end
                    FS_ACK: begin
                        if (fall_ev)
                            state_q <= next_q;
                    end
                    FS_RDATA: begin
                        if (rise_ev) begin
                            cnt_q <= cnt_q + 4'd1;
                        end else if (fall_ev) begin
                            if (cnt_q == 4'd8)
                                state_q <= FS_MACK;
                            else
                                tx_q <= {tx_q[6:0], 1'b1};
                        end
                    end
                    FS_MACK: begin
                        if (fall_ev)
                            state_q <= FS_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
// Register bank: identity values, staged sequence registers with active
// copies, immediate registers, per-channel gain codes and sticky locks.
// Assumes wr_en is a single-cycle strobe with address and data stable.
module cfg_reg_bank
    import cfg_i2c_pkg::*;
#(
    parameter int NCH = 4,
    parameter int GW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [7:0]        wdata,
    input  logic              seq_commit,
    output logic [7:0]        rd_data,
    output logic              lock_wr,
    output logic              lock_all,
    output logic [7:0]        stg_chan,
    output logic [7:0]        act_chan,
    output logic [7:0]        act_skip,
    output logic              act_pol,
    output logic [1:0]        ofs_q,
    output logic [3:0]        cm_q,
    output logic              tmo_q,
    output logic [NCH*GW-1:0] bus_gain_flat,
    output logic [NCH*GW-1:0] shunt_gain_flat
);
    localparam int GLSB = 1;
    localparam int GMSB = GLSB + GW - 1;

    logic [7:0]    stg_skip;
    logic          stg_pol;
    logic [1:0]    lock_q;
    logic [GW-1:0] bg_q [NCH];
    logic [GW-1:0] sg_q [NCH];

    assign lock_all = lock_q[0];
    assign lock_wr  = lock_q[1];

    // Staged sequence registers and the immediate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_chan <= ENA_RST;
            stg_skip <= '0;
            stg_pol  <= 1'b0;
            ofs_q    <= '0;
            cm_q     <= CM_RST;
            tmo_q    <= 1'b0;
            lock_q   <= '0;
        end else if (wr_en) begin
            case (addr)
                REG_ENA:  stg_chan <= wdata & ENA_MASK;
                REG_SKIP: stg_skip <= wdata;
                REG_POL:  stg_pol  <= wdata[7];
                REG_OFS:  ofs_q    <= wdata[1:0];
                REG_CM:   cm_q     <= wdata[3:0];
                REG_TMO:  tmo_q    <= wdata[7];
                REG_LOCK: lock_q   <= lock_q | wdata[1:0];
                default: ;
            endcase
        end
    end

    // Active copies move only at a sequence boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_chan <= ENA_RST;
            act_skip <= '0;
            act_pol  <= 1'b0;
        end else if (seq_commit) begin
            act_chan <= stg_chan;
            act_skip <= stg_skip;
            act_pol  <= stg_pol;
        end
    end

    // One bus-gain and one shunt-gain register per channel.
    for (genvar g = 0; g < NCH; g++) begin : g_gain
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bg_q[g] <= '0;
                sg_q[g] <= '0;
            end else if (wr_en) begin
                if (addr == BUS_BASE + 8'(g)) bg_q[g] <= wdata[GMSB:GLSB];
                if (addr == SHN_BASE + 8'(g)) sg_q[g] <= wdata[GMSB:GLSB];
            end
        end
        assign bus_gain_flat[g*GW +: GW]   = bg_q[g];
        assign shunt_gain_flat[g*GW +: GW] = sg_q[g];
    end

    // Read multiplexer; unmapped addresses and unused bits return zero.
    always_comb begin
        rd_data = '0;
        case (addr)
            REG_ID0:  rd_data = ID0_VAL;
            REG_ID1:  rd_data = ID1_VAL;
            REG_ENA:  rd_data = stg_chan;
            REG_SKIP: rd_data = stg_skip;
            REG_POL:  rd_data = {stg_pol, 7'b0};
            REG_OFS:  rd_data = {6'b0, ofs_q};
            REG_CM:   rd_data = {4'b0, cm_q};
            REG_TMO:  rd_data = {tmo_q, 7'b0};
            REG_LOCK: rd_data = {6'b0, lock_q};
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) begin
            if (addr == BUS_BASE + 8'(i))
                rd_data = 8'({bg_q[i], 1'b0});
            if (addr == SHN_BASE + 8'(i))
                rd_data = 8'({sg_q[i], 1'b0});
        end
    end
endmodule

// File: rtl/cfg_i2c_slave.sv
// Top level: line filters, frame engine and register bank. The bus
// address is a fixed base plus the strap value.
// Assumes the pad logic turns sda_oe into an open-drain pull-down.
module cfg_i2c_slave #(
    parameter int         NCH       = 4,
    parameter int         GW        = 5,
    parameter logic [6:0] ADDR_BASE = 7'h34
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [1:0]        addr_strap,
    input  logic              seq_commit,
    output logic [7:0]        chan_en,
    output logic [3:0]        skip_start,
    output logic [3:0]        skip_end,
    output logic              alt_pol,
    output logic [1:0]        out_offset,
    output logic [3:0]        out_cm,
    output logic              timeout_off,
    output logic [NCH*GW-1:0] bus_gain_flat,
    output logic [NCH*GW-1:0] shunt_gain_flat
);
    logic       scl_f, sda_f;
    logic [6:0] dev_addr;
    logic [7:0] reg_ptr, wr_data, rd_data, chan_stg, skip_act;
    logic       wr_en, lock_wr, lock_all;

    assign dev_addr   = ADDR_BASE + 7'(addr_strap);
    assign skip_start = skip_act[7:4];
    assign skip_end   = skip_act[3:0];

    cfg_pin_filter u_scl (.clk(clk), .rst_n(rst_n), .pin_i(scl_i), .level_o(scl_f));
    cfg_pin_filter u_sda (.clk(clk), .rst_n(rst_n), .pin_i(sda_i), .level_o(sda_f));

    cfg_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .dev_addr(dev_addr), .lock_all(lock_all), .lock_wr(lock_wr),
        .rd_data(rd_data), .reg_ptr(reg_ptr), .wr_en(wr_en),
        .wr_data(wr_data), .sda_oe(sda_oe)
    );

    cfg_reg_bank #(.NCH(NCH), .GW(GW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(reg_ptr),
        .wdata(wr_data), .seq_commit(seq_commit), .rd_data(rd_data),
        .lock_wr(lock_wr), .lock_all(lock_all), .stg_chan(chan_stg),
        .act_chan(chan_en), .act_skip(skip_act), .act_pol(alt_pol),
        .ofs_q(out_offset), .cm_q(out_cm), .tmo_q(timeout_off),
        .bus_gain_flat(bus_gain_flat), .shunt_gain_flat(shunt_gain_flat)
    );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
// Checker bound into the top level: bus drive discipline, lock stickiness
// and staged-register commit behaviour.
module cfg_i2c_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_oe,
    input logic       wr_en,
    input logic       lock_wr,
    input logic       lock_all,
    input logic       seq_commit,
    input logic [7:0] chan_stg,
    input logic [7:0] chan_en
);
    assert_sda_moves_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);
    assert_no_write_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !lock_wr);
    assert_lock_wr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr |=> lock_wr);
    assert_lock_all_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_all |=> lock_all);
    assert_silent_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_all && $past(lock_all) && !$past(sda_oe)) |-> !sda_oe);
    assert_stage_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_commit |=> $stable(chan_en));
    assert_stage_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        seq_commit |=> (chan_en == $past(chan_stg)));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe),
    .wr_en(wr_en), .lock_wr(lock_wr), .lock_all(lock_all),
    .seq_commit(seq_commit), .chan_stg(chan_stg), .chan_en(chan_en)
);

// File: tb/tb_cfg_i2c_slave.sv
`timescale 1ns/1ps
module tb_cfg_i2c_slave;
    localparam int Q = 12;
    localparam logic [6:0] DEV = 7'h36;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0, scl = 1'b1, mlow = 1'b0, commit = 1'b0;
    logic [1:0]  strap = 2'b10;
    logic        sda_oe;
    wire         sda_line = ~(mlow | sda_oe);
    logic [7:0]  chan_en;
    logic [3:0]  skip_start, skip_end, out_cm;
    logic        alt_pol, timeout_off;
    logic [1:0]  out_offset;
    logic [19:0] bus_gain_flat, shunt_gain_flat;

    cfg_i2c_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_strap(strap), .seq_commit(commit), .chan_en(chan_en),
        .skip_start(skip_start), .skip_end(skip_end), .alt_pol(alt_pol),
        .out_offset(out_offset), .out_cm(out_cm), .timeout_off(timeout_off),
        .bus_gain_flat(bus_gain_flat), .shunt_gain_flat(shunt_gain_flat)
    );

    typedef struct { string req; string what; int val; } item_t;
    item_t exp_q[$];
    item_t obs_q[$];
    int checks = 0, errors = 0;
    bit done = 0;

    // Driver side: push the expected value and the observed value.
    task automatic expect_val(string req, string what, int e, int a);
        exp_q.push_back('{req, what, e});
        obs_q.push_back('{req, what, a});
    endtask

    // Monitor: pop and compare in order.
    initial begin : monitor
        item_t e, o;
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0 && obs_q.size() > 0) begin
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                checks++;
                if (e.val != o.val) begin
                    errors++;
                    $display("FAIL %s %s: actual %0h expected %0h", e.req, e.what, o.val, e.val);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic qw(); repeat (Q) @(negedge clk); endtask
    task automatic bus_start();   mlow = 0; scl = 1; qw(); mlow = 1; qw(); scl = 0; qw(); endtask
    task automatic bus_restart(); mlow = 0; qw(); scl = 1; qw(); mlow = 1; qw(); scl = 0; qw(); endtask
    task automatic bus_stop();    mlow = 1; qw(); scl = 1; qw(); mlow = 0; qw(); qw(); endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            mlow = !b[i]; qw(); scl = 1; qw(); qw(); scl = 0; qw();
        end
        mlow = 0; qw(); scl = 1; qw(); ack = sda_line; qw(); scl = 0; qw();
    endtask

    task automatic recv_byte(output logic [7:0] b);
        mlow = 0;
        for (int i = 7; i >= 0; i--) begin
            qw(); scl = 1; qw(); b[i] = sda_line; qw(); scl = 0;
        end
        mlow = 0; qw(); scl = 1; qw(); qw(); scl = 0; qw();
    endtask

    task automatic write_reg(input logic [6:0] a7, input logic [7:0] r, input logic [7:0] d,
                             input string req, input int ea, input int ed);
        logic ack;
        bus_start();
        send_byte({a7, 1'b0}, ack); expect_val(req, "addr ack", ea, int'(ack));
        if (ack == 1'b0) begin
            send_byte(r, ack); expect_val(req, "reg ack", 0, int'(ack));
            send_byte(d, ack); expect_val(req, "data ack", ed, int'(ack));
        end
        bus_stop();
    endtask

    task automatic read_reg(input logic [7:0] r, input int exp, input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte({DEV, 1'b0}, ack); expect_val(req, "rd addr ack", 0, int'(ack));
        send_byte(r, ack);           expect_val(req, "rd reg ack", 0, int'(ack));
        bus_restart();
        send_byte({DEV, 1'b1}, ack); expect_val(req, "rd addr2 ack", 0, int'(ack));
        recv_byte(b);                expect_val(req, $sformatf("read %0h", r), exp, int'(b));
        bus_stop();
    endtask

    task automatic do_reset();
        rst_n = 0; repeat (4) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
    endtask

    task automatic pulse_commit();
        commit = 1; @(negedge clk); commit = 0; @(negedge clk);
    endtask

    initial begin : stim
        logic ack;
        do_reset();
        // R5 reset state at the ports and in read-back
        expect_val("R5", "chan_en", 8'h0F, int'(chan_en));
        expect_val("R5", "out_cm", 7, int'(out_cm));
        expect_val("R5", "out_offset", 0, int'(out_offset));
        expect_val("R5", "gains", 0, int'(bus_gain_flat | shunt_gain_flat));
        expect_val("R5", "sda_oe", 0, int'(sda_oe));
        read_reg(8'h04, 8'h0F, "R5");
        read_reg(8'h08, 8'h07, "R5");
        // R4 identity registers, R3 read path
        read_reg(8'h00, 8'h4F, "R4");
        read_reg(8'h01, 8'h2D, "R3");
        write_reg(DEV, 8'h00, 8'h12, "R4", 0, 0);
        read_reg(8'h00, 8'h4F, "R4");
        // R1 address matching
        write_reg(7'h34, 8'h07, 8'h01, "R1", 1, 1);
        write_reg(7'h37, 8'h07, 8'h01, "R1", 1, 1);
        expect_val("R1", "offset untouched", 0, int'(out_offset));
        // R2/R7 immediate registers, R8 masks
        write_reg(DEV, 8'h07, 8'hFF, "R2", 0, 0);
        expect_val("R7", "out_offset", 3, int'(out_offset));
        read_reg(8'h07, 8'h03, "R8");
        write_reg(DEV, 8'h08, 8'hAC, "R7", 0, 0);
        expect_val("R7", "out_cm", 4'hC, int'(out_cm));
        write_reg(DEV, 8'h0F, 8'hFF, "R7", 0, 0);
        expect_val("R7", "timeout_off", 1, int'(timeout_off));
        read_reg(8'h0F, 8'h80, "R8");
        write_reg(DEV, 8'h12, 8'h3E, "R7", 0, 0);
        expect_val("R7", "bus gain ch2", 5'h1F, int'(bus_gain_flat[14:10]));
        write_reg(DEV, 8'h21, 8'hD5, "R7", 0, 0);
        expect_val("R7", "shunt gain ch1", 5'h0A, int'(shunt_gain_flat[9:5]));
        read_reg(8'h21, 8'h14, "R8");
        // R6 staged registers
        write_reg(DEV, 8'h04, 8'hFF, "R6", 0, 0);
        write_reg(DEV, 8'h05, 8'h5A, "R6", 0, 0);
        write_reg(DEV, 8'h06, 8'hFF, "R6", 0, 0);
        expect_val("R6", "chan_en before commit", 8'h0F, int'(chan_en));
        expect_val("R6", "alt_pol before commit", 0, int'(alt_pol));
        read_reg(8'h04, 8'hBF, "R6");
        read_reg(8'h06, 8'h80, "R8");
        pulse_commit();
        expect_val("R6", "chan_en after commit", 8'hBF, int'(chan_en));
        expect_val("R6", "skip", 8'h5A, int'({skip_start, skip_end}));
        expect_val("R6", "alt_pol after commit", 1, int'(alt_pol));
        // R8 unmapped address
        write_reg(DEV, 8'h30, 8'h55, "R8", 0, 0);
        read_reg(8'h30, 8'h00, "R8");
        // R3 second data byte refused
        bus_start();
        send_byte({DEV, 1'b0}, ack); expect_val("R3", "addr ack", 0, int'(ack));
        send_byte(8'h07, ack);       expect_val("R3", "reg ack", 0, int'(ack));
        send_byte(8'h01, ack);       expect_val("R3", "data1 ack", 0, int'(ack));
        send_byte(8'h02, ack);       expect_val("R3", "data2 nack", 1, int'(ack));
        bus_stop();
        expect_val("R3", "offset from first byte", 1, int'(out_offset));
        // R9 write lock
        write_reg(DEV, 8'h24, 8'h02, "R9", 0, 0);
        write_reg(DEV, 8'h07, 8'h03, "R9", 0, 1);
        expect_val("R9", "offset kept", 1, int'(out_offset));
        read_reg(8'h07, 8'h01, "R9");
        read_reg(8'h24, 8'h02, "R9");
        // R10 full lock, after reset
        do_reset();
        expect_val("R5", "out_offset after reset", 0, int'(out_offset));
        write_reg(DEV, 8'h24, 8'h01, "R10", 0, 0);
        write_reg(DEV, 8'h07, 8'h02, "R10", 1, 1);
        bus_start();
        send_byte({DEV, 1'b1}, ack); expect_val("R10", "read addr nack", 1, int'(ack));
        bus_stop();
        expect_val("R10", "offset kept", 0, int'(out_offset));
        repeat (10) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule